// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block chooses which of a small pool of page frames is given up when a new page must be brought into memory. Each frame carries one usage flag. An access port raises the flag of the frame it names. A persistent pointer remembers the frame most recently given up. When a fault request arrives, the block walks forward around the ring, one frame per clock. A flagged frame is spared and its flag is dropped. The first unflagged frame found is reported as the victim.

Because the walk drops flags as it goes, a fully flagged pool is cleared in one lap. The walk then returns to the frame where it began, which gives first-in-first-out order. When the new page has been placed, a load-complete strobe flags the frame the block last reported, so that frame is not reclaimed at once.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, `busy` and `done` are 0, every frame's flag is clear and `victim` is 0. The first search examines frame 0 first, so it reports frame 0 one cycle after the request.
- R2: An `acc_valid` cycle raises the flag of frame `acc_frame` (index 0 to NUM_FRAMES-1). The next search does not choose a flagged frame.
- R3: A frame passed over by a search has its flag cleared, so a later search that reaches it with no access in between chooses it.
- R4: The search examines one frame per cycle. The first unflagged frame becomes `victim`, and `done` is high for exactly one cycle, k cycles after the clock edge that samples `fault_req`, where k is the number of frames examined.
- R5: Each search begins at the frame one position after the previous victim, wrapping from NUM_FRAMES-1 to 0.
- R6: With every flag raised and no accesses during the search, the search clears all flags in one lap and chooses its starting frame, with k = NUM_FRAMES+1 (9 by default).
- R7: A `load_done` pulse raises the flag of the most recently reported victim.
- R8: An access to the frame being examined, in the same cycle, wins over the clear. That frame is passed over and its flag stays raised.
- R9: `busy` is high from the cycle after the request until the cycle in which `done` rises, and is low in that cycle. A `fault_req` while `busy` is high is ignored and starts no search.
- R10: `victim` holds its value between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_frame | input | 3 | Frame index of the access |
| fault_req | input | 1 | Starts a victim search when idle |
| load_done | input | 1 | Marks the last victim as freshly used |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the victim is valid |
| victim | output | 3 | Index of the chosen frame |

## Verification
The `done` pulse is due k cycles after the edge that samples the request, where k counts the frames examined: 1 for an unflagged start frame, NUM_FRAMES+1 for a full lap, and one more for each passed-over frame in between. The bench drives inputs on the falling edge and samples there. It counts falling edges from the sampling edge until `done` appears, and compares that count and the index with the values a ring model in the bench predicts. `busy` is checked on every one of those falling edges, and the falling edges after `done` confirm that no second pulse occurs and that `victim` holds its value.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/cvs_flag_bank.sv
module cvs_flag_bank #(
    parameter int NUM_FRAMES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FRAMES-1:0] set_vec,
    input  logic [NUM_FRAMES-1:0] clr_vec,
    output logic [NUM_FRAMES-1:0] flags
);
    logic [NUM_FRAMES-1:0] flags_d, flags_q;

    // set wins over clear: a same-cycle access keeps the frame in use
    always_comb begin
        flags_d = set_vec | (flags_q & ~clr_vec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/cvs_walker.sv
module cvs_walker
    import clock_victim_pkg::*;
#(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NUM_FRAMES-1:0] eff_flags,
    output logic [NUM_FRAMES-1:0] clr_vec,
    output logic [IDX_W-1:0]      hand,
    output logic                  busy,
    output logic                  done,
    output logic [IDX_W-1:0]      victim
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    typedef struct packed {
        walk_state_e      state;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] hand;
        logic [IDX_W-1:0] victim;
        logic             done;
    } walk_t;

    walk_t st_d, st_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
        return (i == LAST_IDX) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clr_vec   = '0;
        unique case (st_q.state)
            WALK_IDLE: begin
                if (start) begin
                    st_d.state = WALK_RUN;
                    st_d.ptr   = step(st_q.hand);
                end
            end
            WALK_RUN: begin
                if (eff_flags[st_q.ptr]) begin
                    clr_vec[st_q.ptr] = 1'b1;
                    st_d.ptr          = step(st_q.ptr);
                end else begin
                    st_d.victim = st_q.ptr;
                    st_d.hand   = st_q.ptr;
                    st_d.done   = 1'b1;
                    st_d.state  = WALK_IDLE;
                end
            end
            default: st_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state  <= WALK_IDLE;
            st_q.ptr    <= '0;
            st_q.hand   <= LAST_IDX;
            st_q.victim <= '0;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hand   = st_q.hand;
    assign busy   = (st_q.state == WALK_RUN);
    assign done   = st_q.done;
    assign victim = st_q.victim;

    a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_victim_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(victim));
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int NUM_FRAMES = 8,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             fault_req,
    input  logic             load_done,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim
);
    localparam int CNT_W = $clog2(NUM_FRAMES + 2) + 1;

    logic [NUM_FRAMES-1:0] acc_vec, load_vec, set_vec, clr_vec, flags, eff_flags;
    logic [IDX_W-1:0]      hand;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_decode
        assign acc_vec[g]  = acc_valid && (acc_frame == IDX_W'(g));
        assign load_vec[g] = load_done && (hand == IDX_W'(g));
    end

    assign set_vec   = acc_vec | load_vec;
    assign eff_flags = flags | set_vec;

    cvs_flag_bank #(.NUM_FRAMES(NUM_FRAMES)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    cvs_walker #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) i_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fault_req),
        .eff_flags (eff_flags),
        .clr_vec   (clr_vec),
        .hand      (hand),
        .busy      (busy),
        .done      (done),
        .victim    (victim)
    );

    // search-length watch: busy cycles since the last flag-setting event
    logic [CNT_W-1:0] quiet_d, quiet_q;
    always_comb begin
        quiet_d = (!busy || (set_vec != '0)) ? '0 : quiet_q + 1'b1;
    end
    always_ff @(posedge clk) begin
        if (!rst_n) quiet_q <= '0;
        else        quiet_q <= quiet_d;
    end

    a_r6_lap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (quiet_q <= CNT_W'(NUM_FRAMES)));
    a_r4_victim_unflagged: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flags[victim]);
    a_r2_access_sets: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> flags[$past(acc_frame)]);
endmodule

// File: tb/test_clock_victim_sel.sv
module test_clock_victim_sel;
    localparam int NF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_frame = '0;
    logic       fault_req = 1'b0;
    logic       load_done = 1'b0;
    logic       busy, done;
    logic [2:0] victim;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit       mref [NF];
    int       mhand;

    always #2.5 clk = ~clk;

    clock_victim_sel i_clock_victim_sel (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
        .fault_req(fault_req), .load_done(load_done),
        .busy(busy), .done(done), .victim(victim)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic touch(input int f);
        @(negedge clk);
        acc_valid = 1'b1; acc_frame = 3'(f);
        @(negedge clk);
        acc_valid = 1'b0;
        mref[f] = 1'b1;
    endtask

    task automatic load_strobe();
        @(negedge clk);
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        mref[mhand] = 1'b1;
    endtask

    // hit: access the first examined frame in the same cycle (R8)
    // refault: second request while busy (R9)
    task automatic run_fault(input bit hit, input bit refault, input string req);
        int p, k, n, v0;
        bit first, seen;
        p = (mhand + 1) % NF;
        k = 1;
        first = 1'b1;
        forever begin
            if (first && hit) begin
                mref[p] = 1'b1;
                p = (p + 1) % NF; k++;
            end else if (mref[p]) begin
                mref[p] = 1'b0;
                p = (p + 1) % NF; k++;
            end else break;
            first = 1'b0;
        end
        @(negedge clk);
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        if (hit) begin acc_valid = 1'b1; acc_frame = 3'((mhand + 1) % NF); end
        chk({req, " busy after request"}, int'(busy), 1);
        n = 0; seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
            n++;
            if (refault && n == 2) fault_req = 1'b1;
            else fault_req = 1'b0;
            if (done) begin seen = 1'b1; break; end
            if (busy !== 1'b1) begin
                chk({req, " R9 busy during search"}, int'(busy), 1);
            end
        end
        fault_req = 1'b0;
        chk({req, " done seen"}, int'(seen), 1);
        chk({req, " R4 latency"}, n, k);
        chk({req, " victim"}, int'(victim), p);
        chk({req, " R9 busy low at done"}, int'(busy), 0);
        mhand = p;
        v0 = int'(victim);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk({req, " R9 no extra done"}, int'(done), 0);
            chk({req, " R10 victim held"}, int'(victim), v0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) mref[i] = 1'b0;
        mhand = NF - 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 victim", int'(victim), 0);
        run_fault(1'b0, 1'b0, "R1 first search");
        // R2 R5: flagged frames passed over
        touch(1); touch(2);
        run_fault(1'b0, 1'b0, "R2 skip flagged");
        // R3 R5: lap of searches, cleared frames later chosen
        for (int i = 0; i < 6; i++) run_fault(1'b0, 1'b0, "R3 R5 lap");
        // R6: every flag raised, with a request while busy (R9)
        for (int f = 0; f < NF; f++) touch(f);
        run_fault(1'b0, 1'b1, "R6 full lap");
        run_fault(1'b0, 1'b0, "R6 after lap");
        // R7: load strobe flags last victim
        load_strobe();
        for (int i = 0; i < NF; i++) run_fault(1'b0, 1'b0, "R7 load flag");
        // R8: same-cycle access on examined frame
        run_fault(1'b1, 1'b0, "R8 hit wins");
        for (int i = 0; i < NF; i++) run_fault(1'b0, 1'b0, "R8 kept flag");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule